// File: doc/BRIEF.md
# Pipelined Radix-4 Unsigned Multiplier

This block multiplies two 12-bit unsigned operands and returns the 24-bit product five clocks later. It takes a new operand pair on every clock and has no stall or back-pressure, so a caller can stream one pair per cycle and read one product per cycle after a fixed fill delay. A qualifying strobe travels beside the data, so idle cycles at the input show up as idle cycles at the output.

The first stage registers the triple of A (A plus A shifted left by one), a delayed copy of A and a delayed copy of B. The second stage splits the delayed B into 2-bit digits. Each digit drives a four-way select among zero, A, twice A and the registered triple, and the selected multiple is registered at its weight of four to the power of the digit index. The last three stages are a registered pairwise adder tree that folds the six partial products into three, then two, then one. Each stage carries the full product width, so no carry is dropped.

Width and digit count are parameters. The latency is two plus the depth of the adder tree, which is five for the default 12x12 configuration.

Top module: `mulr4_top`

## Requirements
- R1: A pair (a, b) sampled at a rising edge with in_valid high gives p = a*b as an unsigned 24-bit value. p is valid after the fifth rising edge from that edge and is presented together with out_valid.
- R2: out_valid is high exactly when in_valid was high at the rising edge five edges earlier. A cycle with in_valid low gives a cycle with out_valid low.
- R3: A new pair is accepted on every clock. Pairs presented on consecutive clocks give their own products on consecutive clocks, with no gaps and no mixing.
- R4: rst is synchronous and active high. A rising edge with rst high clears every pipeline register, so out_valid and p are 0 afterwards. Pairs still in flight are discarded, and out_valid stays low for the first five edges after rst falls.
- R5: Digit k of b is b[2k+1:2k]. Code 00 adds 0, code 01 adds a, code 10 adds 2a and code 11 adds 3a, each weighted by 4^k. Every digit position k = 0..5 follows this rule independently.
- R6: The full range is exact. a = b = 4095 gives p = 16769025 (0xFFE001), with no carry lost in any adder stage.
- R7: An operand of 0 on either side gives p = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the whole pipeline |
| in_valid | input | 1 | Marks a, b as a pair to be multiplied |
| a | input | 12 | Multiplicand, unsigned |
| b | input | 12 | Multiplier, unsigned, consumed as six 2-bit digits |
| out_valid | output | 1 | Marks p as the product of the pair sent five clocks earlier |
| p | output | 24 | Unsigned product |

## Verification
Several properties are checked on every cycle against a product and strobe delayed by the checker itself: the five-clock alignment of out_valid with in_valid, the product value of every valid output, the zero result for a zero operand, the clearing effect of reset, and the silent fill window after reset. Some behaviour only the bench scenarios can show. These are the per-digit weighting of each 2-bit code, the all-ones corner, unbroken streams of pairs on consecutive clocks, and a reset that arrives while valid pairs are still inside the pipeline.

// File: rtl/mulr4_pkg.sv
package mulr4_pkg;

    // Code carried by one 2-bit digit of the multiplier.
    typedef enum logic [1:0] {
        DIG_ZERO  = 2'b00,
        DIG_ONE   = 2'b01,
        DIG_TWO   = 2'b10,
        DIG_THREE = 2'b11
    } dig_sel_e;

    // Number of terms left after `lvl` pairwise folding levels.
    function automatic int level_width(input int n, input int lvl);
        int c;
        c = n;
        for (int i = 0; i < lvl; i++) begin
            c = (c + 1) / 2;
        end
        return c;
    endfunction

    // Folding levels needed to bring n terms down to one.
    function automatic int tree_depth(input int n);
        int c;
        int d;
        c = n;
        d = 0;
        for (int i = 0; i < 32; i++) begin
            if (c > 1) begin
                c = (c + 1) / 2;
                d = d + 1;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mulr4_prep.sv
// Stage 1: register the triple of A, and delayed A and B beside it.
module mulr4_prep #(
    parameter int A_W = 12,
    parameter int B_W = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [A_W-1:0] a_q,
    output logic [A_W+1:0] a3_q,
    output logic [B_W-1:0] b_q
);

    logic [A_W+1:0] triple;

    // 3A = A + 2A; the carry chain lives only in this stage
    assign triple = {2'b00, a_in} + {1'b0, a_in, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            a3_q <= '0;
            b_q  <= '0;
        end else begin
            a_q  <= a_in;
            a3_q <= triple;
            b_q  <= b_in;
        end
    end

endmodule

// File: rtl/mulr4_select.sv
// Stage 2: one four-way select per 2-bit digit, registered at its weight.
module mulr4_select
    import mulr4_pkg::*;
#(
    parameter  int A_W  = 12,
    parameter  int B_W  = 12,
    localparam int NDIG = B_W / 2,
    localparam int P_W  = A_W + B_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [A_W-1:0]            a_q,
    input  logic [A_W+1:0]            a3_q,
    input  logic [B_W-1:0]            b_q,
    output logic [NDIG-1:0][P_W-1:0]  pp
);

    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        dig_sel_e       code;
        logic [A_W+1:0] mult;
        logic [P_W-1:0] pq;

        assign code = dig_sel_e'(b_q[2*k +: 2]);

        always_comb begin
            unique case (code)
                DIG_ZERO:  mult = '0;
                DIG_ONE:   mult = {2'b00, a_q};
                DIG_TWO:   mult = {1'b0, a_q, 1'b0};
                DIG_THREE: mult = a3_q;
                default:   mult = '0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pq <= '0;
            end else begin
                pq <= P_W'(mult) << (2 * k);
            end
        end

        assign pp[k] = pq;
    end

endmodule

// File: rtl/mulr4_tree.sv
// Stages 3..: registered pairwise adder tree, full product width throughout.
module mulr4_tree
    import mulr4_pkg::*;
#(
    parameter int P_W = 24,
    parameter int NIN = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NIN-1:0][P_W-1:0]  terms,
    output logic [P_W-1:0]           total
);

    localparam int DEPTH = tree_depth(NIN);

    for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
        localparam int CIN  = level_width(NIN, l - 1);
        localparam int COUT = level_width(NIN, l);

        logic [CIN-1:0][P_W-1:0]  din;
        logic [COUT-1:0][P_W-1:0] dq;

        if (l == 1) begin : g_src
            assign din = terms;
        end else begin : g_src
            assign din = g_lvl[l-1].dq;
        end

        for (genvar i = 0; i < COUT; i++) begin : g_node
            logic [P_W-1:0] nsum;
            logic [P_W-1:0] nq;

            if (2 * i + 1 < CIN) begin : g_add
                assign nsum = din[2*i] + din[2*i+1];
            end else begin : g_pass
                assign nsum = din[2*i];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    nq <= '0;
                end else begin
                    nq <= nsum;
                end
            end

            assign dq[i] = nq;
        end
    end

    assign total = g_lvl[DEPTH].dq[0];

endmodule

// File: rtl/mulr4_top.sv
module mulr4_top
    import mulr4_pkg::*;
#(
    parameter int A_W = 12,
    parameter int B_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [A_W-1:0]       a,
    input  logic [B_W-1:0]       b,
    output logic                 out_valid,
    output logic [A_W+B_W-1:0]   p
);

    localparam int NDIG  = B_W / 2;
    localparam int P_W   = A_W + B_W;
    localparam int DEPTH = tree_depth(NDIG);
    localparam int LAT   = 2 + DEPTH;

    logic [A_W-1:0]           a_q;
    logic [A_W+1:0]           a3_q;
    logic [B_W-1:0]           b_q;
    logic [NDIG-1:0][P_W-1:0] pp;
    logic [LAT-1:0]           vld_q;

    mulr4_prep #(.A_W(A_W), .B_W(B_W)) u_prep (
        .clk  (clk),
        .rst  (rst),
        .a_in (a),
        .b_in (b),
        .a_q  (a_q),
        .a3_q (a3_q),
        .b_q  (b_q)
    );

    mulr4_select #(.A_W(A_W), .B_W(B_W)) u_sel (
        .clk  (clk),
        .rst  (rst),
        .a_q  (a_q),
        .a3_q (a3_q),
        .b_q  (b_q),
        .pp   (pp)
    );

    mulr4_tree #(.P_W(P_W), .NIN(NDIG)) u_tree (
        .clk   (clk),
        .rst   (rst),
        .terms (pp),
        .total (p)
    );

    // Strobe travels beside the data, one register per stage
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[LAT-2:0], in_valid};
        end
    end

    assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/mulr4_chk.sv
module mulr4_chk #(
    parameter int A_W = 12,
    parameter int B_W = 12,
    parameter int LAT = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [A_W-1:0]       a,
    input logic [B_W-1:0]       b,
    input logic                 out_valid,
    input logic [A_W+B_W-1:0]   p
);

    localparam int P_W = A_W + B_W;

    logic [7:0]     warm;
    logic [P_W-1:0] prod_now;
    logic           zero_op;

    assign prod_now = P_W'(a) * P_W'(b);
    assign zero_op  = (a == '0) || (b == '0);

    // Count of non-reset edges since reset, saturating at LAT
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm < 8'(LAT)) begin
            warm <= warm + 8'd1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (warm >= 8'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    p_product_r1: assert property (@(posedge clk) disable iff (rst)
        (warm >= 8'(LAT) && out_valid) |-> (p == $past(prod_now, LAT)));

    p_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (warm >= 8'(LAT) && out_valid && $past(zero_op, LAT)) |-> (p == '0));

    p_clear_r4: assert property (@(posedge clk)
        rst |=> (!out_valid && p == '0));

    p_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (warm < 8'(LAT)) |-> !out_valid);

endmodule

bind mulr4_top mulr4_chk #(.A_W(A_W), .B_W(B_W), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .p         (p)
);

// File: tb/sim_mulr4_top.sv
module sim_mulr4_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] a = '0;
    logic [11:0] b = '0;
    logic        out_valid;
    logic [23:0] p;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic        hv [8];
    logic [23:0] hp [8];
    string       ht [8];

    mulr4_top u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .p         (p)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference product by shift-and-add
    function automatic logic [23:0] ref_mul(input logic [11:0] x, input logic [11:0] y);
        logic [23:0] acc;
        acc = '0;
        for (int i = 0; i < 12; i++) begin
            if (y[i]) acc = acc + (24'(x) << i);
        end
        return acc;
    endfunction

    // One clock: check what leaves, then drive a new pair
    task automatic step(input logic v, input logic [11:0] x, input logic [11:0] y,
                        input string tag);
        int s;
        @(negedge clk);
        s = (cyc + 8 - LAT) % 8;
        total++;
        if (out_valid !== hv[s]) begin
            bad++;
            $display("FAIL R2 out_valid cyc=%0d actual=%b expected=%b", cyc, out_valid, hv[s]);
        end
        if (hv[s]) begin
            total++;
            if (p !== hp[s]) begin
                bad++;
                $display("FAIL %s product cyc=%0d actual=%h expected=%h", ht[s], cyc, p, hp[s]);
            end
        end
        in_valid = v;
        a = x;
        b = y;
        hv[cyc % 8] = v;
        hp[cyc % 8] = ref_mul(x, y);
        ht[cyc % 8] = tag;
        cyc++;
    endtask

    // Reset while pairs are in flight (R4)
    task automatic mid_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        a = 12'($urandom);
        b = 12'($urandom);
        for (int i = 0; i < 8; i++) hv[i] = 1'b0;
        cyc++;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || p !== 24'h0) begin
            bad++;
            $display("FAIL R4 mid reset actual=%b/%h expected=0/000000", out_valid, p);
        end
        rst = 1'b0;
        in_valid = 1'b0;
        hv[cyc % 8] = 1'b0;
        cyc++;
    endtask

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 8; i++) begin
            hv[i] = 1'b0;
            hp[i] = '0;
            ht[i] = "";
        end
        repeat (3) @(negedge clk);
        // R4: reset state
        total++;
        if (out_valid !== 1'b0 || p !== 24'h0) begin
            bad++;
            $display("FAIL R4 reset state actual=%b/%h expected=0/000000", out_valid, p);
        end
        rst = 1'b0;

        // R6, R7: corner operands, back to back (R3)
        step(1'b1, 12'd0,    12'd0,    "R7");
        step(1'b1, 12'd0,    12'd4095, "R7");
        step(1'b1, 12'd4095, 12'd0,    "R7");
        step(1'b1, 12'd1,    12'd1,    "R1");
        step(1'b1, 12'd1,    12'd4095, "R1");
        step(1'b1, 12'd4095, 12'd1,    "R1");
        step(1'b1, 12'd4095, 12'd4095, "R6");
        step(1'b1, 12'd4094, 12'd4095, "R6");

        // R5: each digit code at each position
        for (int k = 0; k < 6; k++) begin
            for (int c = 1; c < 4; c++) begin
                step(1'b1, 12'd4095, 12'(c << (2 * k)), "R5");
                step(1'b1, 12'($urandom), 12'(c << (2 * k)), "R5");
            end
        end
        step(1'b1, 12'd2731, 12'b111001001110, "R5");

        // R2: idle gap
        for (int i = 0; i < 7; i++) step(1'b0, 12'($urandom), 12'($urandom), "R2");

        // R1, R2: random pairs with random gaps
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, 12'($urandom), 12'($urandom), "R1");
        end

        // R4: reset with pairs in flight, then the fill window
        for (int i = 0; i < 4; i++) step(1'b1, 12'($urandom), 12'($urandom), "R4");
        mid_reset();
        for (int i = 0; i < 6; i++) step(1'b0, 12'd0, 12'd0, "R4");

        // R3: unbroken stream
        for (int i = 0; i < 60; i++) step(1'b1, 12'($urandom), 12'($urandom), "R3");
        for (int i = 0; i < 4; i++) step(1'b1, 12'(4095 - i), 12'(4095 - 2 * i), "R6");

        // drain
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 12'd0, 12'd0, "R2");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired at cyc=%0d", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule